// File: doc/BRIEF.md
# UART Framer with Raw Ninth Bit

This block is the serial framer of an asynchronous serial port. On the transmit side it takes one data word from the host and sends it on the line. The frame is a low start bit, the data bits with the least significant bit first, and one high stop bit. On the receive side it finds incoming frames and returns each decoded word together with a framing-error flag. A word-length control picks 8 or 7 data bits. An optional extra bit can follow the data bits. The block sends that bit and captures it exactly as the host supplies it or as it arrives on the line. The block never computes it as parity, so it can carry an address/data marker in 9-bit multidrop networks.

Both directions share a 16x oversampling tick. This tick comes from an external baud divisor, so a bit lasts 16 ticks. The receiver synchronises the line and finds a start on a falling edge. It confirms the start bit at its middle and samples every later bit at its middle. Word length and extra-bit enable are captured at the start of each frame.

Top module: `uart_nbit_framer`

## Requirements
- R1: After reset, `txd` is 1, `tx_busy` is 0 and `rx_valid` is 0. Whenever the transmitter is idle, `txd` stays 1.
- R2: A frame accepted on `tx_load` is sent as 0 (start), then the data bits from bit 0 upward, then 1 (stop). Each bit lasts 16 `baud_tick` pulses, and `txd` changes only after a tick or a load.
- R3: With `seven_bit` = 1, only `tx_word[6:0]` are sent, and `tx_word[7]` has no effect on the line.
- R4: With `extra_en` = 1, `tx_extra` is sent unchanged as one bit between the last data bit and the stop bit. With `extra_en` = 0, no such bit is sent and `tx_extra` has no effect.
- R5: A `tx_load` pulse while `tx_busy` is 1 is ignored. The frame in flight is unchanged and no further frame follows it.
- R6: The receiver returns each frame with a one-cycle `rx_valid` pulse, issued on a tick at the middle of the stop bit. `rx_word` holds the data, least significant bit first on the line.
- R7: With `seven_bit` = 1, the receiver takes 7 data bits and `rx_word[7]` reads 0.
- R8: With `extra_en` = 1, the bit after the data is returned unchanged on `rx_extra`. With `extra_en` = 0, `rx_extra` reads 0.
- R9: A low pulse on `rxd` that has returned high by the middle of the start bit produces no word.
- R10: `rx_frame_err` is 1 with a word whose stop bit was sampled low, and 0 when it was sampled high. The word is delivered in both cases.
- R11: `tx_busy` rises only in the cycle after an accepted `tx_load`. It stays 1 until the stop bit has lasted its full 16 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x oversampling strobe, one cycle wide |
| seven_bit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| extra_en | input | 1 | 1 adds the raw extra bit after the data |
| tx_load | input | 1 | Start a transmit frame (ignored while busy) |
| tx_word | input | 8 | Transmit data word |
| tx_extra | input | 1 | Raw extra bit to send |
| tx_busy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial line out, idle high |
| rxd | input | 1 | Serial line in, asynchronous |
| rx_valid | output | 1 | One-cycle pulse: a received word is ready |
| rx_word | output | 8 | Received data word |
| rx_extra | output | 1 | Received raw extra bit (0 when disabled) |
| rx_frame_err | output | 1 | Stop bit of the returned word was low |

## Verification
The transmit and receive paths run at the same time from the same tick and the same mode inputs. A receiver word can therefore be returned in the same cycle as a transmit bit boundary, or as the moment `tx_busy` falls. The bench provokes this by launching a transmit frame and a receive frame in the same cycle, both in directed and in random full-duplex cases. It judges the result by checking every `txd` bit at its centre against the expected frame, and by checking the returned word, extra bit and error flag against values computed from the driven frame.

// File: rtl/uartfr_pkg.sv
package uartfr_pkg;

  // Frame phase shared by the transmit and receive sequencers
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_EXTRA,
    PH_STOP
  } phase_e;

endpackage

// File: rtl/uartfr_sync.sv
module uartfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  // Line idles high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uartfr_tx.sv
module uartfr_tx
  import uartfr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic              short_mode,
  input  logic              extra_en,
  input  logic [DATA_W-1:0] word,
  input  logic              extra,
  output logic              txd,
  output logic              busy
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              ex_q, ex_d;
  logic              short_q, short_d;
  logic              xen_q, xen_d;
  logic              bit_end;
  logic [IDX_W-1:0]  idx_last;

  assign bit_end  = tick && (cnt_q == CNT_LAST);
  assign idx_last = short_q ? LAST_SHORT : LAST_LONG;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    ex_d    = ex_q;
    short_d = short_q;
    xen_d   = xen_q;

    if (state_q != PH_IDLE && tick) begin
      cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    end

    case (state_q)
      PH_IDLE: begin
        if (load) begin
          state_d = PH_START;
          cnt_d   = '0;
          sh_d    = word;
          if (short_mode) begin
            sh_d[DATA_W-1] = 1'b0;
          end
          ex_d    = extra;
          short_d = short_mode;
          xen_d   = extra_en;
        end
      end
      PH_START: begin
        if (bit_end) begin
          state_d = PH_DATA;
          idx_d   = '0;
        end
      end
      PH_DATA: begin
        if (bit_end) begin
          sh_d  = sh_q >> 1;
          idx_d = idx_q + 1'b1;
          if (idx_q == idx_last) begin
            state_d = xen_q ? PH_EXTRA : PH_STOP;
          end
        end
      end
      PH_EXTRA: begin
        if (bit_end) begin
          state_d = PH_STOP;
        end
      end
      PH_STOP: begin
        if (bit_end) begin
          state_d = PH_IDLE;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      ex_q    <= 1'b0;
      short_q <= 1'b0;
      xen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      ex_q    <= ex_d;
      short_q <= short_d;
      xen_q   <= xen_d;
    end
  end

  always_comb begin
    case (state_q)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh_q[0];
      PH_EXTRA: txd = ex_q;
      default:  txd = 1'b1;
    endcase
  end

  assign busy = (state_q != PH_IDLE);

endmodule

// File: rtl/uartfr_rx.sv
module uartfr_rx
  import uartfr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              short_mode,
  input  logic              extra_en,
  output logic              valid,
  output logic [DATA_W-1:0] word,
  output logic              extra,
  output logic              ferr
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID    = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              ex_q, ex_d;
  logic              short_q, short_d;
  logic              xen_q, xen_d;
  logic              prev_q;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              xo_q, xo_d;
  logic              ferr_q, ferr_d;
  logic              bit_mid;
  logic [IDX_W-1:0]  idx_last;

  // After the start check, the count runs a full bit so samples stay centred
  assign bit_mid  = tick && (cnt_q == CNT_LAST);
  assign idx_last = short_q ? LAST_SHORT : LAST_LONG;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    ex_d    = ex_q;
    short_d = short_q;
    xen_d   = xen_q;
    valid_d = 1'b0;
    word_d  = word_q;
    xo_d    = xo_q;
    ferr_d  = ferr_q;

    if ((state_q == PH_DATA || state_q == PH_EXTRA || state_q == PH_STOP) && tick) begin
      cnt_d = bit_mid ? '0 : cnt_q + 1'b1;
    end

    case (state_q)
      PH_IDLE: begin
        if (prev_q && !line) begin
          state_d = PH_START;
          cnt_d   = '0;
          ex_d    = 1'b0;
          short_d = short_mode;
          xen_d   = extra_en;
        end
      end
      PH_START: begin
        if (tick) begin
          if (cnt_q == CNT_MID) begin
            cnt_d = '0;
            idx_d = '0;
            state_d = line ? PH_IDLE : PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_DATA: begin
        if (bit_mid) begin
          sh_d  = {line, sh_q[DATA_W-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == idx_last) begin
            state_d = xen_q ? PH_EXTRA : PH_STOP;
          end
        end
      end
      PH_EXTRA: begin
        if (bit_mid) begin
          ex_d    = line;
          state_d = PH_STOP;
        end
      end
      PH_STOP: begin
        if (bit_mid) begin
          valid_d = 1'b1;
          word_d  = short_q ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
          xo_d    = xen_q & ex_q;
          ferr_d  = !line;
          state_d = PH_IDLE;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      ex_q    <= 1'b0;
      short_q <= 1'b0;
      xen_q   <= 1'b0;
      prev_q  <= 1'b1;
      valid_q <= 1'b0;
      word_q  <= '0;
      xo_q    <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      ex_q    <= ex_d;
      short_q <= short_d;
      xen_q   <= xen_d;
      prev_q  <= line;
      valid_q <= valid_d;
      word_q  <= word_d;
      xo_q    <= xo_d;
      ferr_q  <= ferr_d;
    end
  end

  assign valid = valid_q;
  assign word  = word_q;
  assign extra = xo_q;
  assign ferr  = ferr_q;

endmodule

// File: rtl/uart_nbit_framer.sv
module uart_nbit_framer #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              seven_bit,
  input  logic              extra_en,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_extra,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_extra,
  output logic              rx_frame_err
);

  logic rxd_sync;

  uartfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rxd_sync)
  );

  uartfr_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .load      (tx_load),
    .short_mode(seven_bit),
    .extra_en  (extra_en),
    .word      (tx_word),
    .extra     (tx_extra),
    .txd       (txd),
    .busy      (tx_busy)
  );

  uartfr_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .line      (rxd_sync),
    .short_mode(seven_bit),
    .extra_en  (extra_en),
    .valid     (rx_valid),
    .word      (rx_word),
    .extra     (rx_extra),
    .ferr      (rx_frame_err)
  );

endmodule

// File: rtl/uartfr_checker.sv
module uartfr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_tick,
  input logic              seven_bit,
  input logic              extra_en,
  input logic              tx_load,
  input logic              tx_busy,
  input logic              txd,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_word,
  input logic              rx_extra
);

  // R1
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R2
  txd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($past(baud_tick) || $past(tx_load)));

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_load));

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  rx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(baud_tick));

  // R7
  rx_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && seven_bit) |-> !rx_word[DATA_W-1]);

  // R8
  rx_extra_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !extra_en) |-> !rx_extra);

endmodule

bind uart_nbit_framer uartfr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .seven_bit(seven_bit),
  .extra_en (extra_en),
  .tx_load  (tx_load),
  .tx_busy  (tx_busy),
  .txd      (txd),
  .rx_valid (rx_valid),
  .rx_word  (rx_word),
  .rx_extra (rx_extra)
);

// File: tb/uart_nbit_framer_bench.sv
module uart_nbit_framer_bench;

  localparam int BITC = 64;  // 16 ticks x 4 clocks per tick

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b0;
  logic       seven_bit, extra_en, tx_load, tx_extra, rxd;
  logic [7:0] tx_word;
  logic       tx_busy, txd, rx_valid, rx_extra, rx_frame_err;
  logic [7:0] rx_word;
  int         tdiv = 0;
  int         vecs = 0;
  int         errs = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == 3) begin
      tdiv <= 0;
      baud_tick <= 1'b1;
    end else begin
      tdiv <= tdiv + 1;
      baud_tick <= 1'b0;
    end
  end

  uart_nbit_framer u_uart_nbit_framer (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .seven_bit(seven_bit),
    .extra_en(extra_en), .tx_load(tx_load), .tx_word(tx_word), .tx_extra(tx_extra),
    .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_extra(rx_extra), .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int frame_len(bit sh, bit xen);
    return 2 + (sh ? 7 : 8) + (xen ? 1 : 0);
  endfunction

  function automatic bit exp_bit(int pos, logic [7:0] w, bit ex, bit sh, bit xen);
    int nd = sh ? 7 : 8;
    if (pos == 0) return 1'b0;
    if (pos <= nd) return w[pos-1];
    if (xen && pos == nd + 1) return ex;
    return 1'b1;
  endfunction

  function automatic string bit_tag(int pos, bit sh, bit xen);
    int nd = sh ? 7 : 8;
    if (pos >= 1 && pos <= nd) return sh ? "R3 data bit" : "R2 data bit";
    if (xen && pos == nd + 1) return "R4 extra bit";
    if (pos == 0) return "R2 start bit";
    return sh ? "R3 stop position" : (xen ? "R2 stop bit" : "R4 no extra, stop bit");
  endfunction

  task automatic run_tx(input logic [7:0] w, input bit ex, input bit poke);
    int n = frame_len(seven_bit, extra_en);
    int waitc = 0;
    @(negedge clk);
    tx_word = w; tx_extra = ex; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_busy == 1'b1, "R11 busy after load", tx_busy, 1);
    while (txd !== 1'b0 && waitc < 8) begin @(negedge clk); waitc++; end
    repeat (32) @(negedge clk);
    for (int pos = 0; pos < n; pos++) begin
      if (pos > 0) begin
        for (int k = 0; k < BITC; k++) begin
          @(negedge clk);
          if (poke && pos == 3 && k == 10) begin
            tx_word = ~w; tx_extra = ~ex; tx_load = 1'b1;
          end else begin
            tx_load = 1'b0;
          end
        end
      end
      chk(txd === exp_bit(pos, w, ex, seven_bit, extra_en), bit_tag(pos, seven_bit, extra_en),
          txd, exp_bit(pos, w, ex, seven_bit, extra_en));
    end
    chk(tx_busy == 1'b1, "R11 busy through stop", tx_busy, 1);
    repeat (48) @(negedge clk);
    chk(tx_busy == 1'b0, "R11 busy drops after stop", tx_busy, 0);
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    if (poke) begin
      repeat (BITC) @(negedge clk);
      chk(txd == 1'b1 && tx_busy == 1'b0, "R5 load while busy ignored", {tx_busy, txd}, 2'b01);
    end
  endtask

  task automatic run_rx(input logic [7:0] w, input bit ex, input bit stopv);
    int n = frame_len(seven_bit, extra_en);
    int idle = stopv ? BITC : 3 * BITC;
    int pulses = 0;
    logic [7:0] gw = '0;
    bit gx = 1'b0, gf = 1'b0;
    logic [7:0] ew = seven_bit ? (w & 8'h7F) : w;
    bit ex_exp = extra_en ? ex : 1'b0;
    @(negedge clk);
    fork
      begin
        for (int pos = 0; pos < n; pos++) begin
          rxd = (pos == n - 1) ? stopv : exp_bit(pos, w, ex, seven_bit, extra_en);
          repeat (BITC) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (idle) @(negedge clk);
      end
      begin
        for (int k = 0; k < n * BITC + idle; k++) begin
          @(negedge clk);
          if (rx_valid) begin
            pulses++; gw = rx_word; gx = rx_extra; gf = rx_frame_err;
          end
        end
      end
    join
    chk(pulses == 1, "R6 one valid pulse per frame", pulses, 1);
    chk(gw == ew, seven_bit ? "R7 received word" : "R6 received word", gw, ew);
    chk(gx == ex_exp, "R8 received extra bit", gx, ex_exp);
    chk(gf == !stopv, "R10 framing error flag", gf, !stopv);
  endtask

  task automatic false_start();
    int pulses = 0;
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    for (int k = 0; k < 16 * BITC; k++) begin
      @(negedge clk);
      if (rx_valid) pulses++;
    end
    chk(pulses == 0, "R9 short low pulse rejected", pulses, 0);
  endtask

  task automatic cfg(input bit sh, input bit xen);
    seven_bit = sh; extra_en = xen;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd9127);
    rst_n = 1'b0; tx_load = 1'b0; tx_word = '0; tx_extra = 1'b0; rxd = 1'b1;
    cfg(0, 0);
    repeat (5) @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(tx_busy == 1'b0, "R1 reset busy", tx_busy, 0);
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cfg(0, 0); run_tx(8'hA5, 1'b1, 1'b0); run_rx(8'h3C, 1'b0, 1'b1);
    cfg(1, 0); run_tx(8'hFF, 1'b1, 1'b0); run_rx(8'hFF, 1'b0, 1'b1);
    cfg(0, 1); run_tx(8'h5A, 1'b1, 1'b0); run_rx(8'h81, 1'b1, 1'b1);
    cfg(0, 0); run_rx(8'h81, 1'b1, 1'b1);
    cfg(1, 1); run_tx(8'hC3, 1'b1, 1'b0); run_rx(8'hC3, 1'b1, 1'b1);
    cfg(0, 0); run_tx(8'h96, 1'b0, 1'b1);
    cfg(0, 1); run_rx(8'h55, 1'b0, 1'b0); run_rx(8'h55, 1'b1, 1'b1);
    cfg(1, 0); false_start(); run_rx(8'h6E, 1'b0, 1'b1);
    cfg(0, 1);
    fork
      run_tx(8'h12, 1'b1, 1'b0);
      run_rx(8'hED, 1'b0, 1'b1);
    join

    for (int i = 0; i < 40; i++) begin
      logic [7:0] wt, wr;
      bit et, er, stp;
      int mode;
      cfg($urandom % 2, $urandom % 2);
      wt = 8'($urandom); wr = 8'($urandom);
      et = 1'($urandom); er = 1'($urandom);
      stp = ($urandom % 5) != 0;
      mode = $urandom % 3;
      if (mode == 0) run_tx(wt, et, ($urandom % 4) == 0);
      else if (mode == 1) run_rx(wr, er, stp);
      else begin
        fork
          run_tx(wt, et, 1'b0);
          run_rx(wr, er, stp);
        join
      end
    end
    summary();
  end

endmodule